// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block watches for a processor that has stopped running its program. A binary counter advances on every system clock. When it reaches the detection time chosen in the mode register, the block raises a one-clock watchdog interrupt and a matching reset-request pulse. The reset-request pulse can be wired to a reset pin or to other devices. The counter then wraps to zero and keeps running. If software does not service it, further pulses follow at the same interval.

Software keeps the watchdog quiet by writing a clear key to the command register at least once per detection period. Turning the watchdog off takes two ordered steps. First the enable bit of the mode register is cleared, then a separate disable key is written to the command register. A stray single write cannot stop it. Setting the enable bit again re-arms the watchdog with the counter at zero.

Power-mode inputs gate the counter. In sleep or stop it is held at zero. In idle, a mode bit decides whether it runs or freezes. A granted-away bus has no effect on counting.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the mode register reads 0x80 (enable bit 7 = 1, select bits 6:5 = 00, idle-run bit 3 = 0), the interrupt is low, and counting starts with no software action. The first pulse comes 2^SEL_BASE clocks after reset is released.
- R2: With select value s in mode bits 6:5, the interrupt and the reset request each pulse high for exactly one clock, 2^(SEL_BASE+s·SEL_STEP) clocks after the counter last started from zero. With the default parameters this gives 2^16, 2^18, 2^20 and 2^22 clocks.
- R3: After a pulse the counter restarts from zero, so without service the next pulse follows one full detection period later.
- R4: Writing the clear key 0x4E to the command register (address 1) restarts the period from zero.
- R5: After mode bit 7 has been written to 0, writing the disable key 0xB1 to the command register stops the watchdog, and no further pulses occur.
- R6: Writing 0xB1 while mode bit 7 is 1 has no effect on the count.
- R7: Command values other than the two keys have no effect on the count.
- R8: Writing mode bit 7 = 1 while the watchdog is stopped restarts it, counting from zero.
- R9: While the sleep or stop input is high, the counter is held at zero. A full period is needed after the input is released.
- R10: While the idle input is high, the counter freezes if mode bit 3 is 0 and runs on if it is 1.
- R11: The bus-granted input has no effect on counting.
- R12: The mode register (address 0) reads back bits 7, 6:5 and 3 as written and all other bits as 0. The command register reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| bus_wr | input | 1 | register write strobe |
| bus_addr | input | 1 | 0 = mode register, 1 = command register |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data for bus_addr |
| pm_idle | input | 1 | device is in idle mode |
| pm_sleep | input | 1 | device is in sleep mode |
| pm_stop | input | 1 | device is in stop mode |
| bus_granted | input | 1 | bus has been handed to another master |
| wdt_irq | output | 1 | one-clock watchdog interrupt pulse |
| wdt_rst_req | output | 1 | one-clock reset-request pulse |

## Verification
The bench builds the block with a 10-bit counter, SEL_BASE = 3 and SEL_STEP = 2. The four detection periods then shrink to 8, 32, 128 and 512 clocks. Every select value, repeated wraps, and each key and power-mode scenario can therefore be timed exactly to the clock within a short run. The step between periods is wide enough that a wrong tap bit or a missed restart shows up as a different pulse time.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // mode register layout; bit positions are software-visible
   typedef struct packed {
      logic       en;       // [7]
      logic [1:0] sel;      // [6:5]
      logic       rsv4;     // [4]
      logic       idle_run; // [3]
      logic [2:0] rsv;      // [2:0]
   } wdt_mode_t;

   localparam logic       ADDR_MODE   = 1'b0;
   localparam logic       ADDR_CMD    = 1'b1;
   localparam logic [7:0] KEY_CLEAR   = 8'h4E;
   localparam logic [7:0] KEY_DISABLE = 8'hB1;
   localparam int         NUM_SEL     = 4;

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
   import wdt_pkg::*;
#(
   parameter logic [7:0] CLEAR_KEY   = KEY_CLEAR,
   parameter logic [7:0] DISABLE_KEY = KEY_DISABLE
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic       bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output wdt_mode_t  mode,
   output logic       wd_on,
   output logic       cnt_clr
);

   logic      wr_mode, wr_cmd, key_clr, key_dis, rearm;
   wdt_mode_t mode_d;

   assign wr_mode = bus_wr && (bus_addr == ADDR_MODE);
   assign wr_cmd  = bus_wr && (bus_addr == ADDR_CMD);
   assign key_clr = wr_cmd && (bus_wdata == CLEAR_KEY);
   assign key_dis = wr_cmd && (bus_wdata == DISABLE_KEY) && !mode.en;
   assign rearm   = wr_mode && bus_wdata[7] && !wd_on;
   assign cnt_clr = key_clr || rearm;

   always_comb begin
      mode_d          = wdt_mode_t'(bus_wdata);
      mode_d.rsv4     = 1'b0;
      mode_d.rsv      = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode  <= '{en: 1'b1, sel: 2'b00, rsv4: 1'b0, idle_run: 1'b0, rsv: 3'b000};
         wd_on <= 1'b1;
      end else begin
         if (wr_mode) mode <= mode_d;
         if (rearm)        wd_on <= 1'b1;
         else if (key_dis) wd_on <= 1'b0;
      end
   end

   assign bus_rdata = (bus_addr == ADDR_MODE) ? 8'(mode) : 8'h00;

   // R6: the disable key is refused while the enable bit is set
   a_r6_key_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && bus_wdata == DISABLE_KEY && mode.en && wd_on) |=> wd_on);
   // R5: the disable key after clearing the enable bit stops the watchdog
   a_r5_two_step_off: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && bus_wdata == DISABLE_KEY && !mode.en) |=> !wd_on);
   // R8: the watchdog comes back on only through a mode write
   a_r8_rearm_path: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_on) |-> $past(wr_mode) && mode.en);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
   import wdt_pkg::*;
#(
   parameter int CNT_W    = 22,
   parameter int SEL_BASE = 16,
   parameter int SEL_STEP = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  wdt_mode_t  mode,
   input  logic       wd_on,
   input  logic       cnt_clr,
   input  logic       pm_idle,
   input  logic       pm_sleep,
   input  logic       pm_stop,
   input  logic       bus_granted,
   output logic       irq,
   output logic       rst_req
);

   localparam int TOP_SH = SEL_BASE + (NUM_SEL - 1) * SEL_STEP;

   if (SEL_BASE < 1)     $error("wdt_counter: SEL_BASE must be at least 1");
   if (SEL_STEP < 1)     $error("wdt_counter: SEL_STEP must be at least 1");
   if (TOP_SH > CNT_W)   $error("wdt_counter: longest period does not fit CNT_W");

   logic [CNT_W-1:0] lim_tab [NUM_SEL];
   logic [CNT_W-1:0] cnt;
   logic             hold_zero, run, wrap;

   for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
      localparam int SH = SEL_BASE + g * SEL_STEP;
      assign lim_tab[g] = {CNT_W{1'b1}} >> (CNT_W - SH);
   end

   // bus grant deliberately takes no part in the gating
   logic unused_grant;
   assign unused_grant = bus_granted;

   assign hold_zero = !wd_on || pm_sleep || pm_stop || cnt_clr;
   assign run       = !pm_idle || mode.idle_run;
   assign wrap      = (cnt == lim_tab[mode.sel]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         irq     <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         irq     <= 1'b0;
         rst_req <= 1'b0;
         if (hold_zero) begin
            cnt <= '0;
         end else if (run) begin
            if (wrap) begin
               cnt     <= '0;
               irq     <= 1'b1;
               rst_req <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R2: each interrupt lasts one clock
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R3: a pulse leaves the counter restarted from zero
   a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cnt == '0));
   // R9: sleep and stop force the count to zero
   a_r9_low_power_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_sleep || pm_stop) |=> (cnt == '0) && !irq);
   // R10: idle without the run bit freezes the count
   a_r10_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_idle && !mode.idle_run && !hold_zero) |=> $stable(cnt));
   // R2: reset request follows the interrupt
   a_r2_req_matches: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req == irq);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import wdt_pkg::*;
#(
   parameter int         CNT_W       = 22,
   parameter int         SEL_BASE    = 16,
   parameter int         SEL_STEP    = 2,
   parameter logic [7:0] CLEAR_KEY   = KEY_CLEAR,
   parameter logic [7:0] DISABLE_KEY = KEY_DISABLE
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic       bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       pm_idle,
   input  logic       pm_sleep,
   input  logic       pm_stop,
   input  logic       bus_granted,
   output logic       wdt_irq,
   output logic       wdt_rst_req
);

   if (CLEAR_KEY == DISABLE_KEY) $error("keyed_watchdog: keys must differ");

   wdt_mode_t mode;
   logic      wd_on, cnt_clr;

   wdt_ctrl #(
      .CLEAR_KEY   (CLEAR_KEY),
      .DISABLE_KEY (DISABLE_KEY)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .mode      (mode),
      .wd_on     (wd_on),
      .cnt_clr   (cnt_clr)
   );

   wdt_counter #(
      .CNT_W    (CNT_W),
      .SEL_BASE (SEL_BASE),
      .SEL_STEP (SEL_STEP)
   ) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode        (mode),
      .wd_on       (wd_on),
      .cnt_clr     (cnt_clr),
      .pm_idle     (pm_idle),
      .pm_sleep    (pm_sleep),
      .pm_stop     (pm_stop),
      .bus_granted (bus_granted),
      .irq         (wdt_irq),
      .rst_req     (wdt_rst_req)
   );

   // R5: a stopped watchdog raises nothing
   a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_on |=> !wdt_irq);

endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

   localparam int CNT_W    = 10;
   localparam int SEL_BASE = 3;
   localparam int SEL_STEP = 2;

   localparam logic [7:0] VEC_MODE [4] = '{8'h80, 8'hA0, 8'hC0, 8'hE0};
   localparam int         VEC_PER  [4] = '{8, 32, 128, 512};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       pm_idle = 1'b0, pm_sleep = 1'b0, pm_stop = 1'b0, bus_granted = 1'b0;
   logic       wdt_irq, wdt_rst_req;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   keyed_watchdog #(
      .CNT_W    (CNT_W),
      .SEL_BASE (SEL_BASE),
      .SEL_STEP (SEL_STEP)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .pm_idle     (pm_idle),
      .pm_sleep    (pm_sleep),
      .pm_stop     (pm_stop),
      .bus_granted (bus_granted),
      .wdt_irq     (wdt_irq),
      .wdt_rst_req (wdt_rst_req)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = 8'h00;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // clocks from now until the next pulse; also compares the reset request
   task automatic wait_pulse(input string req, input int exp);
      int c = 0;
      do begin
         @(negedge clk);
         c++;
      end while (!wdt_irq && c < 2000);
      check(c == exp, req, c, exp);
      check(wdt_rst_req == wdt_irq, {req, " rst_req"}, int'(wdt_rst_req), int'(wdt_irq));
   endtask

   task automatic quiet(input string req, input int n);
      int hits = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (wdt_irq || wdt_rst_req) hits++;
      end
      check(hits == 0, req, hits, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] rv;
      tick(3);
      // R1: reset state
      rd(1'b0, rv);
      check(rv == 8'h80, "R1 mode reset", int'(rv), 8'h80);
      check(!wdt_irq, "R1 irq reset", int'(wdt_irq), 0);
      @(negedge clk);
      rst_n = 1'b1;
      wait_pulse("R1 first pulse", 8);

      // R2/R3/R12: vector table over all select values
      for (int i = 0; i < 4; i++) begin
         wr(1'b0, VEC_MODE[i]);
         rd(1'b0, rv);
         check(rv == VEC_MODE[i], "R12 mode readback", int'(rv), int'(VEC_MODE[i]));
         wr(1'b1, 8'h4E);
         wait_pulse("R2 period", VEC_PER[i]);
         wait_pulse("R3 repeat period", VEC_PER[i]);
      end

      wr(1'b0, 8'hA0);
      // R4: clear key restarts the period
      wr(1'b1, 8'h4E); tick(20); wr(1'b1, 8'h4E);
      wait_pulse("R4 clear restart", 32);

      // R6: disable key with enable set is ignored
      wr(1'b1, 8'h4E); tick(10); wr(1'b1, 8'hB1);
      wait_pulse("R6 disable refused", 21);

      // R7: other command values ignored
      wr(1'b1, 8'h4E); tick(5); wr(1'b1, 8'h4F); wr(1'b1, 8'h00);
      wait_pulse("R7 junk command", 25);

      // R5: two-step disable
      wr(1'b0, 8'h20); wr(1'b1, 8'hB1);
      quiet("R5 disabled silent", 600);
      rd(1'b0, rv);
      check(rv == 8'h20, "R5 mode after disable", int'(rv), 8'h20);

      // R8: re-enable counts from zero
      wr(1'b0, 8'hA0);
      wait_pulse("R8 re-enable", 32);

      // R9: sleep then stop hold the counter at zero
      wr(1'b1, 8'h4E); tick(20);
      pm_sleep = 1'b1; quiet("R9 sleep silent", 100); pm_sleep = 1'b0;
      wait_pulse("R9 after sleep", 32);
      wr(1'b1, 8'h4E); tick(20);
      pm_stop = 1'b1; quiet("R9 stop silent", 100); pm_stop = 1'b0;
      wait_pulse("R9 after stop", 32);

      // R10: idle freezes with run bit 0, runs with run bit 1
      wr(1'b1, 8'h4E); tick(10);
      pm_idle = 1'b1; quiet("R10 idle frozen", 100); pm_idle = 1'b0;
      wait_pulse("R10 resume after idle", 22);
      wr(1'b0, 8'hA8); wr(1'b1, 8'h4E);
      pm_idle = 1'b1;
      wait_pulse("R10 idle running", 32);
      pm_idle = 1'b0;

      // R11: bus grant does not stop counting
      wr(1'b0, 8'hA0); wr(1'b1, 8'h4E);
      bus_granted = 1'b1;
      wait_pulse("R11 bus granted", 32);
      bus_granted = 1'b0;

      // R12: reserved bits read zero, command reads zero
      wr(1'b0, 8'hFF);
      rd(1'b0, rv);
      check(rv == 8'hE8, "R12 reserved bits", int'(rv), 8'hE8);
      rd(1'b1, rv);
      check(rv == 8'h00, "R12 command read", int'(rv), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule